// File: doc/BRIEF.md
# Hash Input Staging Controller

This block sits between a 32-bit register bus and a hash compression engine. Software or a DMA engine writes message words to a single data address. The block reverses the byte order of each word, so that it arrives in the big-endian order the engine expects, and stores it in an input buffer at the position given by an internal word counter. Once a full block has been gathered, the block starts the engine. The trigger is an explicit start command, the arrival of the last word, or the same last-word trigger paced by a DMA request. The block length is 16 words when the narrow algorithm family is selected and 32 words when the wide family is selected.

When the engine reports completion, the block raises a data-ready flag. This flag can also drive an interrupt. In DMA mode the block asks for the next block of words at the same moment. Digest words from the engine are byte-reversed again on the read port, so they read back in little-endian order. Writes that the block cannot accept set a sticky error flag.

Top module: `hash_stage_ctrl`

## Requirements
- R1: After reset every output is low, the mode is manual (code 0), the block length is 16 words, and the error, ready and request flags are clear.
- R2: An accepted data word (address 2) is stored byte-reversed: bits [7:0] of the written word become bits [31:24] of the buffered word, and so on for the other bytes.
- R3: Accepted data words fill buffer slots 0, 1, 2 … in arrival order, all through the one address 2. Slot i appears on `core_block[32*i +: 32]`, and the counter returns to slot 0 after the last slot of a block.
- R4: In manual mode (code 0, with code 3 acting the same), `core_start` pulses only for a write of control bit 0 (address 0) while a full block is buffered and the engine is idle. A start write in any other situation has no effect.
- R5: In automatic mode (code 1), `core_start` is high for exactly one cycle, starting in the cycle after the write of a block's last word.
- R6: Configuration bit 2 selects the block length: 0 gives 16 words and 1 gives 32 words. `core_wide` shows this bit.
- R7: In DMA mode (code 2), `dma_req` rises when the mode is entered and again on each engine completion. It falls on the first accepted word of a block, and the last word starts the engine as in R5.
- R8: A data write while the engine is busy, or while a full manual block awaits its start, is not stored and sets `err`. `err` stays set until a soft reset (control bit 1).
- R9: `ready` is set by `core_done` while busy. It is cleared by an accepted data word or by a start. `irq` equals `ready` when configuration bit 3 is set, and is low otherwise.
- R10: `dig_word` is digest word `dig_sel` taken from `core_digest[32*dig_sel +: 32]`, with its byte order reversed.
- R11: A configuration write (address 1, mode in bits [1:0]) while idle returns the counter to slot 0 and discards a partial or pending block. A configuration write while busy is ignored.
- R12: A soft reset returns the counter to slot 0, discards a pending block and clears `err`. It leaves the mode settings unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 control, 1 configuration, 2 data |
| reg_wdata | input | 32 | Write data |
| dig_sel | input | 4 | Digest word index for readback |
| dig_word | output | 32 | Selected digest word, little-endian |
| core_start | output | 1 | One-cycle start pulse to the engine |
| core_wide | output | 1 | Wide algorithm family selected |
| core_block | output | 1024 | Buffered block, slot i at bits 32*i+31:32*i |
| core_done | input | 1 | Engine completion pulse |
| core_digest | input | 512 | Engine digest, big-endian words |
| busy | output | 1 | Engine is processing a block |
| ready | output | 1 | Data-ready flag |
| err | output | 1 | Sticky discarded-write flag |
| irq | output | 1 | Interrupt, ready gated by its enable |
| dma_req | output | 1 | DMA block request |

## Verification
The hardest state to reach from the ports is a data write or configuration write that lands while the engine is busy, or in the same cycle as its completion. The stub engine holds busy for a fixed number of cycles, and the stimulus issues those writes directly after the last word of a block, inside that window. Long and short blocks are mixed. Partial blocks are interrupted by configuration writes and by soft resets, so that a stale counter position would show up as misplaced words in `core_block`, which the bench compares on every cycle.

// File: rtl/hash_stage_pkg.sv
package hash_stage_pkg;

    typedef enum logic [1:0] {
        MODE_MANUAL = 2'd0,
        MODE_AUTO   = 2'd1,
        MODE_DMA    = 2'd2,
        MODE_RSVD   = 2'd3
    } hmode_e;

    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_CFG  = 2'd1;
    localparam logic [1:0] ADR_DATA = 2'd2;

    localparam int CTRL_START = 0;
    localparam int CTRL_SRST  = 1;
    localparam int CFG_WIDE   = 2;
    localparam int CFG_IRQEN  = 3;

    typedef struct packed {
        hmode_e mode;
        logic   wide;
        logic   irq_en;
        logic   busy;
        logic   full;
        logic   ready;
        logic   err;
        logic   dreq;
        logic   start;
    } hstate_t;

endpackage

// File: rtl/hash_byte_rev.sv
module hash_byte_rev #(
    parameter int NBYTES = 4
) (
    input  logic [8*NBYTES-1:0] din,
    output logic [8*NBYTES-1:0] dout
);
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign dout[8*g +: 8] = din[8*(NBYTES-1-g) +: 8];
    end
endmodule

// File: rtl/hash_word_ctr.sv
module hash_word_ctr #(
    parameter int DEPTH = 32,
    parameter int SHORT = 16,
    localparam int W    = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic         wide,
    output logic [W-1:0] cnt,
    output logic         at_last
);
    localparam logic [W-1:0] LAST_LONG  = W'(DEPTH - 1);
    localparam logic [W-1:0] LAST_SHORT = W'(SHORT - 1);

    logic [W-1:0] cnt_d, cnt_q;

    assign at_last = wide ? (cnt_q == LAST_LONG) : (cnt_q == LAST_SHORT);
    assign cnt     = cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = at_last ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/hash_in_buf.sv
module hash_in_buf #(
    parameter int WORDS = 32,
    parameter int WW    = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [AW-1:0]       waddr,
    input  logic [WW-1:0]       wdata,
    output logic [WORDS*WW-1:0] flat
);
    for (genvar g = 0; g < WORDS; g++) begin : g_slot
        logic [WW-1:0] slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (we && (waddr == AW'(g))) slot_d = wdata;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_d;
        end

        assign flat[g*WW +: WW] = slot_q;
    end
endmodule

// File: rtl/hash_stage_ctrl.sv
module hash_stage_ctrl
    import hash_stage_pkg::*;
#(
    parameter int MAX_WORDS   = 32,
    parameter int SHORT_WORDS = 16,
    parameter int DIG_WORDS   = 16,
    localparam int WORD_W     = 32,
    localparam int CNT_W      = $clog2(MAX_WORDS),
    localparam int DSEL_W     = $clog2(DIG_WORDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr,
    input  logic [1:0]                  reg_addr,
    input  logic [WORD_W-1:0]           reg_wdata,
    input  logic [DSEL_W-1:0]           dig_sel,
    output logic [WORD_W-1:0]           dig_word,
    output logic                        core_start,
    output logic                        core_wide,
    output logic [MAX_WORDS*WORD_W-1:0] core_block,
    input  logic                        core_done,
    input  logic [DIG_WORDS*WORD_W-1:0] core_digest,
    output logic                        busy,
    output logic                        ready,
    output logic                        err,
    output logic                        irq,
    output logic                        dma_req
);
    hstate_t s_d, s_q;

    logic              accept;
    logic              ctr_clr;
    logic              go;
    logic              at_last;
    logic [CNT_W-1:0]  slot;
    logic [WORD_W-1:0] wdata_be;
    logic [WORD_W-1:0] dig_raw;

    hash_byte_rev #(.NBYTES(WORD_W/8)) u_in_rev (
        .din  (reg_wdata),
        .dout (wdata_be)
    );

    hash_word_ctr #(.DEPTH(MAX_WORDS), .SHORT(SHORT_WORDS)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ctr_clr),
        .inc     (accept),
        .wide    (s_q.wide),
        .cnt     (slot),
        .at_last (at_last)
    );

    hash_in_buf #(.WORDS(MAX_WORDS), .WW(WORD_W)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (accept),
        .waddr (slot),
        .wdata (wdata_be),
        .flat  (core_block)
    );

    assign dig_raw = core_digest[dig_sel*WORD_W +: WORD_W];

    hash_byte_rev #(.NBYTES(WORD_W/8)) u_out_rev (
        .din  (dig_raw),
        .dout (dig_word)
    );

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        accept    = 1'b0;
        ctr_clr   = 1'b0;
        go        = 1'b0;

        if (core_done && s_q.busy) begin
            s_d.busy  = 1'b0;
            s_d.ready = 1'b1;
            if (s_q.mode == MODE_DMA) s_d.dreq = 1'b1;
        end

        if (reg_wr) begin
            unique case (reg_addr)
                ADR_CTRL: begin
                    if (reg_wdata[CTRL_SRST]) begin
                        s_d.full = 1'b0;
                        s_d.err  = 1'b0;
                        ctr_clr  = 1'b1;
                    end else if (reg_wdata[CTRL_START] && s_q.full && !s_q.busy) begin
                        go = 1'b1;
                    end
                end
                ADR_CFG: begin
                    if (!s_q.busy) begin
                        s_d.mode   = hmode_e'(reg_wdata[1:0]);
                        s_d.wide   = reg_wdata[CFG_WIDE];
                        s_d.irq_en = reg_wdata[CFG_IRQEN];
                        s_d.full   = 1'b0;
                        s_d.dreq   = (reg_wdata[1:0] == MODE_DMA);
                        ctr_clr    = 1'b1;
                    end
                end
                ADR_DATA: begin
                    if (s_q.busy || s_q.full) begin
                        s_d.err = 1'b1;
                    end else begin
                        accept    = 1'b1;
                        s_d.ready = 1'b0;
                        s_d.dreq  = 1'b0;
                        if (at_last) begin
                            if (s_q.mode == MODE_AUTO || s_q.mode == MODE_DMA) go = 1'b1;
                            else s_d.full = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end

        if (go) begin
            s_d.start = 1'b1;
            s_d.busy  = 1'b1;
            s_d.ready = 1'b0;
            s_d.full  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{mode: MODE_MANUAL, default: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign core_start = s_q.start;
    assign core_wide  = s_q.wide;
    assign busy       = s_q.busy;
    assign ready      = s_q.ready;
    assign err        = s_q.err;
    assign irq        = s_q.ready & s_q.irq_en;
    assign dma_req    = s_q.dreq;
endmodule

// File: rtl/hash_stage_chk.sv
module hash_stage_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [1:0] reg_addr,
    input logic       srst_bit,
    input logic       core_start,
    input logic       core_done,
    input logic       busy,
    input logic       ready,
    input logic       err,
    input logic       irq,
    input logic       dma_req
);
    a_r5_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start);

    a_r4_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> busy);

    a_r4_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> !$past(busy));

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(reg_wr && reg_addr == 2'd0 && srst_bit)) |=> err);

    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !core_done) |=> busy);

    a_r9_ready_from_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(core_done));

    a_r9_irq_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ready);

    a_r7_no_req_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !dma_req);
endmodule

bind hash_stage_ctrl hash_stage_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .srst_bit   (reg_wdata[1]),
    .core_start (core_start),
    .core_done  (core_done),
    .busy       (busy),
    .ready      (ready),
    .err        (err),
    .irq        (irq),
    .dma_req    (dma_req)
);

// File: tb/sim_hash_stage_ctrl.sv
`timescale 1ns/1ps
module sim_hash_stage_ctrl;
    localparam int LAT = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [31:0]   reg_wdata = '0;
    logic [3:0]    dig_sel = '0;
    logic [31:0]   dig_word;
    logic          core_start;
    logic          core_wide;
    logic [1023:0] core_block;
    logic          core_done = 1'b0;
    logic [511:0]  core_digest = '0;
    logic          busy, ready, err, irq, dma_req;

    int n_chk = 0;
    int n_fail = 0;
    int n_start = 0;

    always #4 clk = ~clk;

    hash_stage_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .dig_sel(dig_sel), .dig_word(dig_word),
        .core_start(core_start), .core_wide(core_wide), .core_block(core_block),
        .core_done(core_done), .core_digest(core_digest), .busy(busy),
        .ready(ready), .err(err), .irq(irq), .dma_req(dma_req)
    );

    function automatic logic [31:0] rev(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [1023:0] act, input logic [1023:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int          m_mode, m_cnt;
    bit          m_wide, m_irqen, m_busy, m_full, m_ready, m_err, m_dreq, m_start;
    logic [31:0] m_buf [32];

    always @(posedge clk) begin
        bit ob, of, go;
        logic [1023:0] eb;
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_wide = 0; m_irqen = 0; m_busy = 0;
            m_full = 0; m_ready = 0; m_err = 0; m_dreq = 0; m_start = 0;
            foreach (m_buf[i]) m_buf[i] = '0;
        end else begin
            ob = m_busy; of = m_full; go = 0; m_start = 0;
            if (core_done && ob) begin
                m_busy = 0; m_ready = 1;
                if (m_mode == 2) m_dreq = 1;
            end
            if (reg_wr) begin
                if (reg_addr == 2'd0) begin
                    if (reg_wdata[1]) begin m_full = 0; m_err = 0; m_cnt = 0; end
                    else if (reg_wdata[0] && of && !ob) go = 1;
                end else if (reg_addr == 2'd1) begin
                    if (!ob) begin
                        m_mode = int'(reg_wdata[1:0]); m_wide = reg_wdata[2];
                        m_irqen = reg_wdata[3]; m_full = 0; m_cnt = 0;
                        m_dreq = (reg_wdata[1:0] == 2'd2);
                    end
                end else if (reg_addr == 2'd2) begin
                    if (ob || of) m_err = 1;
                    else begin
                        m_buf[m_cnt] = rev(reg_wdata); m_ready = 0; m_dreq = 0;
                        if (m_cnt == (m_wide ? 31 : 15)) begin
                            m_cnt = 0;
                            if (m_mode == 1 || m_mode == 2) go = 1; else m_full = 1;
                        end else m_cnt++;
                    end
                end
            end
            if (go) begin m_start = 1; m_busy = 1; m_ready = 0; m_full = 0; end
        end
        #2;
        for (int i = 0; i < 32; i++) eb[i*32 +: 32] = m_buf[i];
        chk(core_block === eb, "R3 core_block", core_block, eb);
        chk(core_start === m_start, "R5 core_start", 1024'(core_start), 1024'(m_start));
        chk(busy === m_busy, "R4 busy", 1024'(busy), 1024'(m_busy));
        chk(core_wide === m_wide, "R6 core_wide", 1024'(core_wide), 1024'(m_wide));
        chk(dma_req === m_dreq, "R7 dma_req", 1024'(dma_req), 1024'(m_dreq));
        chk(err === m_err, "R8 err", 1024'(err), 1024'(m_err));
        chk(ready === m_ready, "R9 ready", 1024'(ready), 1024'(m_ready));
        chk(irq === (m_ready & m_irqen), "R9 irq", 1024'(irq), 1024'(m_ready & m_irqen));
        chk(dig_word === rev(core_digest[dig_sel*32 +: 32]), "R10 dig_word",
            1024'(dig_word), 1024'(rev(core_digest[dig_sel*32 +: 32])));
    end

    // fixed-latency engine stub
    int cd = 0;
    always @(negedge clk) begin
        dig_sel = dig_sel + 4'd1;
        if (!rst_n) begin
            core_done = 1'b0; cd = 0;
        end else begin
            core_done = 1'b0;
            if (cd > 0) begin
                cd--;
                if (cd == 0) core_done = 1'b1;
            end
            if (core_start) begin
                n_start++;
                cd = LAT;
                for (int i = 0; i < 16; i++)
                    core_digest[i*32 +: 32] = core_block[i*32 +: 32] ^ {16'hA5C3, 16'(i)};
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic burst(input int n, input logic [31:0] base);
        for (int i = 0; i < n; i++) wr(2'd2, base + 32'(i * 32'h01010101));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 40 && busy; i++) @(negedge clk);
        idle(1);
    endtask

    task automatic expect_starts(input int exp, input string tag);
        chk(n_start == exp, tag, 1024'(n_start), 1024'(exp));
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        // R1: reset state
        chk({core_start, busy, ready, err, irq, dma_req, core_wide} == 7'd0,
            "R1 reset outputs", 1024'({core_start, busy, ready, err, irq, dma_req, core_wide}), 1024'(0));
        rst_n = 1'b1;
        idle(2);

        // manual, narrow, irq enabled
        wr(2'd1, 32'h8);
        wr(2'd2, 32'h67452301);
        chk(core_block[31:0] == 32'h01234567, "R2 byte reversal", 1024'(core_block[31:0]), 1024'(32'h01234567));
        burst(15, 32'h11223344);
        idle(2);
        expect_starts(0, "R4 no start before command");
        wr(2'd2, 32'hDEADBEEF);
        chk(err == 1'b1, "R8 write on pending block", 1024'(err), 1024'(1));
        wr(2'd0, 32'h1);
        idle(1);
        expect_starts(1, "R4 start command");
        wait_idle();
        chk(irq == 1'b1, "R9 irq after done", 1024'(irq), 1024'(1));
        wr(2'd0, 32'h2);
        chk(err == 1'b0, "R12 soft reset clears err", 1024'(err), 1024'(0));
        wr(2'd0, 32'h1);
        idle(1);
        expect_starts(1, "R4 start without block ignored");

        // automatic, narrow
        wr(2'd1, 32'h1);
        burst(16, 32'hA0B0C0D0);
        idle(1);
        expect_starts(2, "R5 automatic start");
        wr(2'd2, 32'h55AA55AA);
        wr(2'd1, 32'h6);
        wait_idle();
        chk(core_wide == 1'b0, "R11 config ignored while busy", 1024'(core_wide), 1024'(0));

        // automatic, wide
        wr(2'd1, 32'h5);
        burst(16, 32'h01020304);
        idle(2);
        expect_starts(2, "R6 no start at 16 in wide mode");
        burst(16, 32'h90807060);
        idle(1);
        expect_starts(3, "R6 start at 32");
        wr(2'd2, 32'h12345678);
        wait_idle();

        // config write discards a partial block
        wr(2'd1, 32'h1);
        burst(5, 32'hCAFE0000);
        wr(2'd1, 32'h1);
        burst(15, 32'hBEEF0000);
        idle(2);
        expect_starts(3, "R11 partial block discarded");
        burst(1, 32'h77777777);
        idle(1);
        expect_starts(4, "R11 block restarts at slot 0");
        wait_idle();

        // soft reset discards a partial block
        burst(3, 32'h33330000);
        wr(2'd0, 32'h2);
        burst(16, 32'h44440000);
        idle(1);
        expect_starts(5, "R12 counter back to slot 0");
        chk(core_block[31:0] == rev(32'h44440000), "R12 first slot rewritten",
            1024'(core_block[31:0]), 1024'(rev(32'h44440000)));
        wait_idle();

        // DMA mode, narrow then wide
        wr(2'd1, 32'h2);
        chk(dma_req == 1'b1, "R7 request on entry", 1024'(dma_req), 1024'(1));
        for (int b = 0; b < 2; b++) begin
            burst(16, 32'h0F0E0D0C + 32'(b));
            idle(1);
            wait_idle();
            chk(dma_req == 1'b1, "R7 request after done", 1024'(dma_req), 1024'(1));
        end
        expect_starts(7, "R7 DMA blocks started");
        wr(2'd1, 32'h6);
        burst(32, 32'h10203040);
        wait_idle();
        expect_starts(8, "R7 wide DMA block");
        idle(4);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule